// File: doc/BRIEF.md
# Multicycle Processor Core with Indexed Load and Three-Operand Add

This block is a 32-bit load/store processor that executes each instruction over several clock cycles. A control state machine steps one shared ALU, one two-read-port register file and one unified memory port through each instruction. The base set is word load and store, branch-if-equal, absolute jump, and the register-register operations add, subtract, and, or, and signed set-less-than. The usual opcode and function encodings are used.

Two instructions extend that set. The first is a load whose address is the sum of two registers. The second is an add of three source registers. Neither adds arithmetic hardware. The indexed load steers a third register field onto the second read port. The three-operand add makes two passes through the same ALU, and between them it reads its third operand in a state of its own. Only multiplexer inputs and control states are added.

The core talks to a memory that the environment owns. Memory reads are combinational from the address, and writes take effect at the clock edge while the write strobe is high.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the core returns to the fetch state with PC = 0. In the first cycle after reset is released it presents address 0 with `mem_we` low.
- R2: Every instruction starts with a fetch cycle that reads the word at PC and advances PC by 4. Unless a branch or jump redirects it, the next fetch is at the following word.
- R3: For opcode 0x00, the function codes work as follows, each writing register rd (bits 15:11) from rs (25:21) and rt (20:16): 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, and 0x2A signed set-less-than (result 1 or 0).
- R4: A load (opcode 0x23) writes Mem[rs + sign-extended imm16] into rt. A store (opcode 0x2B) writes rt to that address. Negative offsets count down from the base.
- R5: Branch-if-equal (opcode 0x04) jumps to PC+4+(sign-extended imm16 << 2) when rs equals rt. Otherwise it falls through to PC+4.
- R6: Jump (opcode 0x02) continues at {PC+4 bits 31:28, imm26, 2'b00}.
- R7: An indexed load (opcode 0x00, function 0x01) writes Mem[Reg[rs] + Reg[rd]] into register rt and never writes rd. It is correct even when rt equals rs.
- R8: A three-operand add (opcode 0x18, fields rs 25:21, rt 20:16, rd 15:11, rx 10:6, bits 5:0 ignored) writes Reg[rs]+Reg[rt]+Reg[rx] modulo 2^32 into rd. It takes two ALU passes, reading rx through the second read port. It is correct when rd or rx repeat a source.
- R9: Register 0 always reads as zero. A write that names it has no effect.
- R10: Cycle counts per instruction, fetch included: load 5, indexed load 5, three-operand add 5, store 4, register-register 4, branch 3, jump 3.
- R11: Memory is written only while a store executes, once per store, at the store's computed address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address for instruction fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_rdata | input | 32 | Combinational read data at `mem_addr` |

## Verification
Two things can collide in one cycle. In the first pass of the three-operand add, the ALU sums rs and rt while the register file is already reading rx into the operand latch that the second pass consumes. In the indexed load, the register whose value supplied the address is also the load's destination. The program provokes both with repeated register numbers: a three-operand add whose rd and rx equal rs, and an indexed load whose rt equals rs. Both results are stored and compared with sums and memory words that bench functions compute from seeded random data. Signed extremes are used as well. The total cycle count up to a marker store is also checked against the per-instruction costs.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_LOAD = 6'h23;
   localparam logic [5:0] OPC_STOR = 6'h2B;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_JMP  = 6'h02;
   localparam logic [5:0] OPC_ADD3 = 6'h18;

   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_SLT  = 6'h2A;
   localparam logic [5:0] FN_LIDX = 6'h01;

   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_MEMADR, S_IDXADR, S_MEMRD, S_MEMWB, S_MEMWR,
      S_REXEC, S_RWB, S_BRANCH, S_JUMP, S_ADD3A, S_ADD3B, S_ADD3WB
   } state_e;

   typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
   typedef enum logic [1:0] {SA_PC, SA_REGA, SA_ACC} srca_e;
   typedef enum logic [1:0] {SB_REGB, SB_FOUR, SB_IMM, SB_IMMSH} srcb_e;
   typedef enum logic [1:0] {RP2_RT, RP2_RD, RP2_RX} rport2_e;
   typedef enum logic [1:0] {PCN_ALU, PCN_ACC, PCN_JMP} pcsel_e;

   typedef struct packed {
      logic    pc_we;
      logic    pc_cond;
      pcsel_e  pc_sel;
      logic    use_acc_addr;
      logic    mem_we;
      logic    ir_we;
      logic    reg_we;
      logic    dst_rd;
      logic    wd_from_mem;
      srca_e   srca;
      srcb_e   srcb;
      alu_op_e aluop;
      rport2_e rport2;
   } ctrl_t;

   function automatic logic fn_is_arith(input logic [5:0] fn);
      return fn == FN_ADD || fn == FN_SUB || fn == FN_AND || fn == FN_OR || fn == FN_SLT;
   endfunction

   function automatic alu_op_e fn_to_aluop(input logic [5:0] fn);
      case (fn)
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_SLT:  return ALU_SLT;
         default: return ALU_ADD;
      endcase
   endfunction

endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
   import mcpu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  alu_op_e         op,
   output logic [XLEN-1:0] res,
   output logic            zero
);

   logic lt;

   generate
      if (SLT_SIGNED) begin : g_slt_s
         assign lt = $signed(opa) < $signed(opb);
      end else begin : g_slt_u
         assign lt = opa < opb;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_SUB: res = opa - opb;
         ALU_AND: res = opa & opb;
         ALU_OR:  res = opa | opb;
         ALU_SLT: res = {{(XLEN-1){1'b0}}, lt};
         default: res = opa + opb;
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
   parameter int XLEN     = 32,
   parameter int REG_CNT  = 32,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(REG_CNT)
) (
   input  logic            clk,
   input  logic [AW-1:0]   raddr1,
   input  logic [AW-1:0]   raddr2,
   output logic [XLEN-1:0] rdata1,
   output logic [XLEN-1:0] rdata2,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata
);

   logic [XLEN-1:0] regs [REG_CNT];

   always_ff @(posedge clk) begin
      if (we) regs[waddr] <= wdata;
   end

   generate
      if (ZERO_REG) begin : g_zero
         assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
         assign rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];
      end else begin : g_plain
         assign rdata1 = regs[raddr1];
         assign rdata2 = regs[raddr2];
      end
   endgenerate

endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
   import mcpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl,
   output state_e     state
);

   state_e nxt;
   logic   is_lidx;

   assign is_lidx = (opcode == OPC_REG) && (funct == FN_LIDX);

   always_ff @(posedge clk) begin
      if (rst) state <= S_FETCH;
      else     state <= nxt;
   end

   always_comb begin
      ctl = '{pc_we: 1'b0, pc_cond: 1'b0, pc_sel: PCN_ALU, use_acc_addr: 1'b0,
             mem_we: 1'b0, ir_we: 1'b0, reg_we: 1'b0, dst_rd: 1'b0,
             wd_from_mem: 1'b0, srca: SA_REGA, srcb: SB_REGB, aluop: ALU_ADD,
             rport2: RP2_RT};
      nxt = S_FETCH;
      case (state)
         S_FETCH: begin
            ctl.ir_we = 1'b1;
            ctl.srca  = SA_PC;
            ctl.srcb  = SB_FOUR;
            ctl.pc_we = 1'b1;
            nxt       = S_DECODE;
         end
         S_DECODE: begin
            ctl.srca   = SA_PC;
            ctl.srcb   = SB_IMMSH;
            ctl.rport2 = is_lidx ? RP2_RD : RP2_RT;
            case (opcode)
               OPC_LOAD, OPC_STOR: nxt = S_MEMADR;
               OPC_BEQ:            nxt = S_BRANCH;
               OPC_JMP:            nxt = S_JUMP;
               OPC_ADD3:           nxt = S_ADD3A;
               OPC_REG: begin
                  if (is_lidx)               nxt = S_IDXADR;
                  else if (fn_is_arith(funct)) nxt = S_REXEC;
                  else                       nxt = S_FETCH;
               end
               default:            nxt = S_FETCH;
            endcase
         end
         S_MEMADR: begin
            ctl.srcb = SB_IMM;
            nxt      = (opcode == OPC_LOAD) ? S_MEMRD : S_MEMWR;
         end
         S_IDXADR: begin
            nxt = S_MEMRD;
         end
         S_MEMRD: begin
            ctl.use_acc_addr = 1'b1;
            nxt              = S_MEMWB;
         end
         S_MEMWB: begin
            ctl.reg_we      = 1'b1;
            ctl.wd_from_mem = 1'b1;
         end
         S_MEMWR: begin
            ctl.use_acc_addr = 1'b1;
            ctl.mem_we       = 1'b1;
         end
         S_REXEC: begin
            ctl.aluop = fn_to_aluop(funct);
            nxt       = S_RWB;
         end
         S_RWB: begin
            ctl.reg_we = 1'b1;
            ctl.dst_rd = 1'b1;
         end
         S_BRANCH: begin
            ctl.aluop   = ALU_SUB;
            ctl.pc_cond = 1'b1;
            ctl.pc_sel  = PCN_ACC;
         end
         S_JUMP: begin
            ctl.pc_we  = 1'b1;
            ctl.pc_sel = PCN_JMP;
         end
         S_ADD3A: begin
            ctl.rport2 = RP2_RX;
            nxt        = S_ADD3B;
         end
         S_ADD3B: begin
            ctl.srca = SA_ACC;
            nxt      = S_ADD3WB;
         end
         S_ADD3WB: begin
            ctl.reg_we = 1'b1;
            ctl.dst_rd = 1'b1;
         end
         default: nxt = S_FETCH;
      endcase
   end

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
   import mcpu_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          REG_CNT    = 32,
   parameter logic [31:0] RESET_PC   = 32'h0,
   parameter bit          SLT_SIGNED = 1'b1,
   parameter bit          ZERO_REG   = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic        mem_we,
   input  logic [31:0] mem_rdata
);

   localparam int AW     = $clog2(REG_CNT);
   localparam int IMM_W  = 16;
   localparam int JMP_W  = 26;
   localparam int SEXT_W = XLEN - IMM_W;

   initial begin
      assert (XLEN == 32) else $error("mcpu_core: XLEN must equal the 32-bit instruction word");
      assert (REG_CNT >= 2 && REG_CNT <= 32 && (REG_CNT & (REG_CNT - 1)) == 0)
         else $error("mcpu_core: REG_CNT must be a power of two from 2 to 32");
      assert (RESET_PC[1:0] == 2'b00) else $error("mcpu_core: RESET_PC must be word aligned");
   end

   ctrl_t  ctl;
   state_e state;

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, acc_q;
   logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_res, imm_ext, imm_sh, jmp_tgt, pc_nxt, rf_wdata;
   logic            alu_zero, pc_en, rf_we;
   logic [AW-1:0]   rf_raddr1, rf_raddr2, rf_waddr;
   logic [AW-1:0]   f_rs, f_rt, f_rd, f_rx;

   mcpu_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (ir_q[31:26]),
      .funct  (ir_q[5:0]),
      .ctl    (ctl),
      .state  (state)
   );

   assign f_rs = ir_q[21 +: AW];
   assign f_rt = ir_q[16 +: AW];
   assign f_rd = ir_q[11 +: AW];
   assign f_rx = ir_q[6 +: AW];

   assign rf_raddr1 = f_rs;

   always_comb begin
      case (ctl.rport2)
         RP2_RD:  rf_raddr2 = f_rd;
         RP2_RX:  rf_raddr2 = f_rx;
         default: rf_raddr2 = f_rt;
      endcase
   end

   assign rf_we    = ctl.reg_we;
   assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
   assign rf_wdata = ctl.wd_from_mem ? mdr_q : acc_q;

   mcpu_regfile #(
      .XLEN     (XLEN),
      .REG_CNT  (REG_CNT),
      .ZERO_REG (ZERO_REG)
   ) u_rf (
      .clk    (clk),
      .raddr1 (rf_raddr1),
      .raddr2 (rf_raddr2),
      .rdata1 (rd1),
      .rdata2 (rd2),
      .we     (rf_we),
      .waddr  (rf_waddr),
      .wdata  (rf_wdata)
   );

   assign imm_ext = {{SEXT_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign imm_sh  = imm_ext << 2;

   always_comb begin
      case (ctl.srca)
         SA_PC:   alu_a = pc_q;
         SA_ACC:  alu_a = acc_q;
         default: alu_a = a_q;
      endcase
      case (ctl.srcb)
         SB_FOUR:  alu_b = XLEN'(4);
         SB_IMM:   alu_b = imm_ext;
         SB_IMMSH: alu_b = imm_sh;
         default:  alu_b = b_q;
      endcase
   end

   mcpu_alu #(
      .XLEN       (XLEN),
      .SLT_SIGNED (SLT_SIGNED)
   ) u_alu (
      .opa  (alu_a),
      .opb  (alu_b),
      .op   (ctl.aluop),
      .res  (alu_res),
      .zero (alu_zero)
   );

   assign jmp_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[JMP_W-1:0], 2'b00};

   always_comb begin
      case (ctl.pc_sel)
         PCN_ACC: pc_nxt = acc_q;
         PCN_JMP: pc_nxt = jmp_tgt;
         default: pc_nxt = alu_res;
      endcase
   end

   assign pc_en = ctl.pc_we | (ctl.pc_cond & alu_zero);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= RESET_PC;
         ir_q  <= '0;
         mdr_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         acc_q <= '0;
      end else begin
         if (pc_en)     pc_q <= pc_nxt;
         if (ctl.ir_we) ir_q <= mem_rdata;
         mdr_q <= mem_rdata;
         a_q   <= rd1;
         b_q   <= rd2;
         acc_q <= alu_res;
      end
   end

   assign mem_addr  = ctl.use_acc_addr ? acc_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk
   import mcpu_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int AW   = 5
) (
   input logic            clk,
   input logic            rst,
   input logic [31:0]     mem_addr,
   input logic            mem_we,
   input state_e          state,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] ir,
   input logic            rf_we,
   input logic [AW-1:0]   waddr,
   input logic [AW-1:0]   raddr2
);

   AST_RESET_FETCH_ZERO: assert property (@(posedge clk)
      rst |=> (mem_addr == 32'h0 && !mem_we)); // R1

   AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      state == S_FETCH |=> pc == $past(pc) + XLEN'(4)); // R2

   AST_REG_DEST_RD: assert property (@(posedge clk) disable iff (rst)
      (rf_we && ir[31:26] == OPC_REG && ir[5:0] != FN_LIDX) |-> waddr == ir[11 +: AW]); // R3

   AST_LIDX_DEST_RT: assert property (@(posedge clk) disable iff (rst)
      (rf_we && ir[31:26] == OPC_REG && ir[5:0] == FN_LIDX) |-> waddr == ir[16 +: AW]); // R7

   AST_ADD3_RX_PORT: assert property (@(posedge clk) disable iff (rst)
      state == S_ADD3A |-> raddr2 == ir[6 +: AW]); // R8

   AST_ADD3_TWO_PASS: assert property (@(posedge clk) disable iff (rst)
      state == S_ADD3B |-> $past(state) == S_ADD3A); // R8

   AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> ir[31:26] == OPC_STOR); // R11

   AST_STORE_ONCE: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we); // R11

endmodule

bind mcpu_core mcpu_core_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_addr (mem_addr),
   .mem_we   (mem_we),
   .state    (state),
   .pc       (pc_q),
   .ir       (ir_q),
   .rf_we    (rf_we),
   .waddr    (rf_waddr),
   .raddr2   (rf_raddr2)
);

// File: tb/mcpu_core_test.sv
module mcpu_core_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;

   logic [31:0] mem [256];
   logic [31:0] img [256];
   int          bad_wr;
   int          checks = 0;
   int          fails  = 0;
   int          wp;
   int          cost_sum;
   int          exp_marker;

   always #(CLK_P/2) clk = ~clk;

   mcpu_core uut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (rst) begin
         mem    <= img;
         bad_wr <= 0;
      end else if (mem_we) begin
         mem[mem_addr[9:2]] <= mem_wdata;
         if (mem_addr < 32'h300 || mem_addr > 32'h3FC || mem_addr[1:0] != 2'b00 ||
             mem_addr == 32'h328 || mem_addr == 32'h330)
            bad_wr <= bad_wr + 1;
      end
   end

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_a3(int rd, int rs, int rt, int rx);
      return {6'h18, 5'(rs), 5'(rt), 5'(rd), 5'(rx), 6'h2F};
   endfunction
   function automatic logic [31:0] enc_j(int word);
      return {6'h02, 26'(word)};
   endfunction

   task automatic emit(input logic [31:0] w, input int cost);
      img[wp] = w;
      wp++;
      cost_sum += cost;
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
      end
   endtask

   task automatic build(input logic [31:0] d0, d1, d2, d3, input logic [31:0] sent);
      for (int i = 0; i < 256; i++) img[i] = 32'h0;
      img[127] = d3;
      img[128] = d0;
      img[129] = d1;
      img[130] = d2;
      img[131] = 32'h200;
      img[132] = 32'h8;
      img[202] = sent;
      img[204] = sent;
      wp = 0;
      cost_sum = 0;
      emit(enc_i(6'h23, 0, 1, 16'h200), 5);
      emit(enc_i(6'h23, 0, 2, 16'h204), 5);
      emit(enc_i(6'h23, 0, 3, 16'h208), 5);
      emit(enc_r(1, 2, 4, 6'h20), 4);
      emit(enc_r(1, 2, 5, 6'h22), 4);
      emit(enc_r(1, 2, 6, 6'h24), 4);
      emit(enc_r(1, 2, 7, 6'h25), 4);
      emit(enc_r(1, 2, 8, 6'h2A), 4);
      emit(enc_a3(9, 1, 2, 3), 5);
      for (int r = 4; r <= 9; r++) emit(enc_i(6'h2B, 0, r, 16'(32'h300 + (r - 4) * 4)), 4);
      emit(enc_i(6'h23, 0, 11, 16'h20C), 5);
      emit(enc_i(6'h23, 0, 12, 16'h210), 5);
      emit(enc_r(12, 13, 11, 6'h01), 5);
      emit(enc_i(6'h2B, 0, 13, 16'h318), 4);
      emit(enc_r(12, 12, 11, 6'h01), 5);
      emit(enc_i(6'h2B, 0, 12, 16'h31C), 4);
      emit(enc_a3(1, 1, 2, 1), 5);
      emit(enc_i(6'h2B, 0, 1, 16'h320), 4);
      emit(enc_r(2, 2, 0, 6'h20), 4);
      emit(enc_i(6'h2B, 0, 0, 16'h324), 4);
      emit(enc_i(6'h04, 3, 3, 16'h0001), 3);
      emit(enc_i(6'h2B, 0, 2, 16'h328), 0);
      emit(enc_i(6'h04, 2, 3, 16'h0001), 3);
      emit(enc_i(6'h2B, 0, 3, 16'h32C), 4);
      emit(enc_j(wp + 2), 3);
      emit(enc_i(6'h2B, 0, 3, 16'h330), 0);
      emit(enc_i(6'h23, 11, 14, 16'hFFFC), 5);
      emit(enc_i(6'h2B, 0, 14, 16'h334), 4);
      emit(enc_a3(15, 5, 6, 7), 5);
      emit(enc_i(6'h2B, 0, 15, 16'h338), 4);
      exp_marker = cost_sum + 3;
      emit(enc_i(6'h2B, 0, 4, 16'h3FC), 4);
      emit(enc_j(wp), 3);
   endtask

   function automatic logic [31:0] at(int byte_addr);
      return mem[byte_addr / 4];
   endfunction

   task automatic run_round(input logic [31:0] d0, d1, d2, d3);
      logic [31:0] sent;
      int          cyc;
      bit          seen;
      sent = 32'h5AA5_0000 ^ d3;
      build(d0, d1, d2, d3, sent);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(mem_we == 1'b0, "R1 no write during reset", {31'd0, mem_we}, 32'h0);
      rst = 1'b0;
      #1;
      check(mem_addr == 32'h0 && !mem_we, "R1 first fetch address", mem_addr, 32'h0);
      cyc = 0;
      seen = 1'b0;
      while (!seen && cyc < 2000) begin
         @(negedge clk);
         cyc++;
         if (cyc == 5) check(mem_addr == 32'h4, "R2 second fetch address", mem_addr, 32'h4);
         if (mem_we && mem_addr == 32'h3FC) seen = 1'b1;
      end
      check(seen && cyc == exp_marker, "R10 cycles to marker store", cyc, exp_marker);
      repeat (4) @(negedge clk);
      check(at(32'h300) == d0 + d1, "R3 add", at(32'h300), d0 + d1);
      check(at(32'h304) == d0 - d1, "R3 sub", at(32'h304), d0 - d1);
      check(at(32'h308) == (d0 & d1), "R3 and", at(32'h308), d0 & d1);
      check(at(32'h30C) == (d0 | d1), "R3 or", at(32'h30C), d0 | d1);
      check(at(32'h310) == {31'd0, $signed(d0) < $signed(d1)}, "R3 slt signed",
            at(32'h310), {31'd0, $signed(d0) < $signed(d1)});
      check(at(32'h314) == d0 + d1 + d2, "R8 three-operand add", at(32'h314), d0 + d1 + d2);
      check(at(32'h318) == d2, "R7 indexed load", at(32'h318), d2);
      check(at(32'h31C) == d2, "R7 indexed load rt==rs", at(32'h31C), d2);
      check(at(32'h320) == d0 + d1 + d0, "R8 add3 rd and rx repeat rs", at(32'h320), d0 + d1 + d0);
      check(at(32'h324) == 32'h0, "R9 register 0 write ignored", at(32'h324), 32'h0);
      check(at(32'h328) == sent, "R5 taken branch skips", at(32'h328), sent);
      check(at(32'h32C) == d2, "R5 untaken branch falls through", at(32'h32C), d2);
      check(at(32'h330) == sent, "R6 jump skips", at(32'h330), sent);
      check(at(32'h334) == d3, "R4 load negative offset", at(32'h334), d3);
      check(at(32'h338) == (d0 - d1) + (d0 & d1) + (d0 | d1), "R8 add3 distinct regs",
            at(32'h338), (d0 - d1) + (d0 & d1) + (d0 | d1));
      check(at(32'h3FC) == d0 + d1, "R4 store marker", at(32'h3FC), d0 + d1);
      check(bad_wr == 0, "R11 stray memory writes", bad_wr, 0);
   endtask

   initial begin
      logic [31:0] a, b, c, d;
      void'($urandom(32'd20240517));
      run_round(32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF);
      a = $urandom();
      c = a ^ 32'h0000_0100;
      run_round(a, a, c, $urandom());
      for (int k = 0; k < 4; k++) begin
         a = $urandom();
         b = $urandom();
         c = $urandom();
         d = $urandom();
         if (b == c) c = ~b;
         run_round(a, b, c, d);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule